// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block buffers 9-bit words between two unrelated clocks. A producer pushes words on the write clock, a consumer pops them on the read clock, and the words come out in the order they went in. Storage is a dual-port word array addressed by a write pointer and a read pointer. Each pointer is passed to the other clock as a Gray-coded value through a chain of synchronizer flops.

Each side has its own status flags, all active low. The write side has a full flag and an almost-full flag. The read side has an empty flag and an almost-empty flag. The almost-full threshold m and the almost-empty threshold n are offsets loaded from the data input. Both start at 7 after reset.

The input `wr_en2_ld` has two uses, chosen by the `DUAL_WEN` parameter:
- With `DUAL_WEN` = 1 it is a second write qualifier.
- With `DUAL_WEN` = 0 it is the strobe that loads the offsets.

A single asynchronous reset returns both sides to empty.

Top module: `dcfifo_flags`

## Requirements
- R1: Words are delivered on `rd_data` in the order they were accepted, with all 9 bits intact, and none is lost or repeated.
- R2: A write takes place on a rising `wclk` edge only when `wr_en` is high, `wr_full_n` is high and the configuration qualifier holds. `wr_full_n` goes low exactly when the write side sees DEPTH unread words. Writes attempted while it is low are dropped.
- R3: With `DUAL_WEN` = 1, a write also needs `wr_en2_ld` high. A write attempt with it low stores nothing.
- R4: A read takes place on a rising `rclk` edge only when `rd_en_a`, `rd_en_b` and `rd_empty_n` are all high. Otherwise `rd_data` holds its value. `rd_empty_n` is low when the read side sees no unread word, and it changes only on `rclk`.
- R5: With `DUAL_WEN` = 0, a `wclk` edge with `wr_en` and `wr_en2_ld` both high loads the low AW bits of `wr_data` into an offset and writes no word. The offsets load alternately: first m, then n, then m again.
- R6: `wr_afull_n` is a `wclk` register. It is low when the write-side unread count is at least DEPTH - m, and high once the free locations exceed m.
- R7: `rd_aempty_n` is an `rclk` register. It is low when the read-side unread count is at most n.
- R8: Reset gives the following state:
  - `rd_data` = 0.
  - `rd_empty_n` and `rd_aempty_n` low.
  - `wr_full_n` and `wr_afull_n` high.
  - m = n = 7.
  - The load sequence restarts at m.
- R9: Pointers cross clock domains only as Gray codes. Each register edge changes at most one bit of a crossing pointer.
- R10: For a word written into an empty FIFO, `rd_empty_n` rises on the second `rclk` edge after the `wclk` edge that stored it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Asynchronous reset, active high, to both domains |
| wr_en | input | 1 | Primary write enable |
| wr_en2_ld | input | 1 | Second write enable (DUAL_WEN=1) or offset-load strobe (DUAL_WEN=0) |
| wr_data | input | DW | Write data, also the offset value during a load |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| rd_data | output | DW | Registered read data |
| wr_full_n | output | 1 | Full flag, active low, write domain |
| wr_afull_n | output | 1 | Almost-full flag, active low, write domain |
| rd_empty_n | output | 1 | Empty flag, active low, read domain |
| rd_aempty_n | output | 1 | Almost-empty flag, active low, read domain |

## Verification
The assertions run on every cycle of each clock and check the following:
- The full and almost-full flags agree with the write-side unread count and the current m.
- The empty flag agrees with the read-side unread count.
- Full implies almost-full, and empty implies almost-empty.
- Neither count ever exceeds DEPTH.
- `rd_data` is frozen on any edge where the FIFO is empty.
- Every Gray pointer changes by at most one bit per edge.

The bench scenarios are needed for the rest:
- End-to-end word order across the two clocks.
- The exact latency of the first word.
- The alternating offset load, and that a load writes nothing.
- Blocking by the second write enable and by a single read enable.
- Restoration of the default thresholds after a reset in mid-traffic.

// File: rtl/dcfifo_pkg.sv
`timescale 1ns/1ps
package dcfifo_pkg;

  // Widest pointer the helpers handle (AW + 1 must not exceed it).
  localparam int PTR_MAXW = 16;
  typedef logic [PTR_MAXW-1:0] ptr_t;

  // Binary to reflected Gray code.
  function automatic ptr_t to_gray(ptr_t b);
    return b ^ (b >> 1);
  endfunction

  // Reflected Gray code back to binary.
  // Upper bits of a narrower pointer are zero, so the result is correct.
  function automatic ptr_t from_gray(ptr_t g);
    ptr_t b;
    b[PTR_MAXW-1] = g[PTR_MAXW-1];
    for (int i = PTR_MAXW - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/dcfifo_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for a Gray-coded pointer.
// q_pre is the value that q takes on the next edge.
module dcfifo_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_pre,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stg[i] <= stg[i-1];
      end
    end
  end

  assign q_pre = stg[STAGES-2];
  assign q     = stg[STAGES-1];

endmodule

// File: rtl/dcfifo_mem.sv
`timescale 1ns/1ps
// Word array: one write port on wclk, one combinational read port.
module dcfifo_mem #(
  parameter int DW = 9,
  parameter int AW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int WORDS = 1 << AW;

  logic [DW-1:0] arr [WORDS];

  always_ff @(posedge wclk) begin
    if (we) arr[waddr] <= wdata;
  end

  assign rdata = arr[raddr];

endmodule

// File: rtl/dcfifo_wctl.sv
`timescale 1ns/1ps
// Write-domain control: write pointer, full / almost-full flags, offset registers.
module dcfifo_wctl
  import dcfifo_pkg::*;
#(
  parameter int DEPTH    = 512,
  parameter int AW       = 9,
  parameter int DW       = 9,
  parameter bit DUAL_WEN = 1'b0,
  parameter int DEF_OFS  = 7
) (
  input  logic          wclk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_en2_ld,
  input  logic [DW-1:0] wr_data,
  input  logic [AW:0]   rgray_q,
  input  logic [AW:0]   rgray_pre,
  output logic          wr_fire,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          full_n,
  output logic          afull_n,
  output logic [AW:0]   wr_count,
  output logic [AW-1:0] ofs_m,
  output logic [AW-1:0] ofs_n
);

  localparam int PW = AW + 1;

  logic [AW-1:0] ofs_in, m_nxt, n_nxt;
  logic          ld_fire, ld_sel;
  logic [PW-1:0] wbin, wbin_nxt, rbin_q, rbin_pre, lvl_nxt, lim;
  ptr_t          t_rq, t_rp, t_wg;

  // Map the data word onto the offset width.
  generate
    if (DW >= AW) begin : g_ofs_trunc
      assign ofs_in = wr_data[AW-1:0];
    end else begin : g_ofs_ext
      assign ofs_in = {{(AW-DW){1'b0}}, wr_data};
    end
  endgenerate

  // Role of the second enable.
  generate
    if (DUAL_WEN) begin : g_dual
      assign wr_fire = wr_en && wr_en2_ld && full_n;
      assign ld_fire = 1'b0;
    end else begin : g_prog
      assign wr_fire = wr_en && !wr_en2_ld && full_n;
      assign ld_fire = wr_en && wr_en2_ld;
    end
  endgenerate

  always_comb begin
    t_rq     = from_gray(ptr_t'(rgray_q));
    t_rp     = from_gray(ptr_t'(rgray_pre));
    rbin_q   = t_rq[PW-1:0];
    rbin_pre = t_rp[PW-1:0];
    wbin_nxt = wbin + PW'(wr_fire);
    m_nxt    = (ld_fire && !ld_sel) ? ofs_in : ofs_m;
    n_nxt    = (ld_fire &&  ld_sel) ? ofs_in : ofs_n;
    // Level after this edge, against the read pointer as it will be synced.
    lvl_nxt  = wbin_nxt - rbin_pre;
    lim      = PW'(DEPTH) - {1'b0, m_nxt};
    t_wg     = to_gray(ptr_t'(wbin_nxt));
    wr_count = wbin - rbin_q;
    waddr    = wbin[AW-1:0];
  end

  always_ff @(posedge wclk or posedge rst) begin
    if (rst) begin
      wbin    <= '0;
      wgray   <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
      ofs_m   <= AW'(DEF_OFS);
      ofs_n   <= AW'(DEF_OFS);
      ld_sel  <= 1'b0;
    end else begin
      wbin    <= wbin_nxt;
      wgray   <= t_wg[PW-1:0];
      full_n  <= (lvl_nxt != PW'(DEPTH));
      afull_n <= (lvl_nxt < lim);
      ofs_m   <= m_nxt;
      ofs_n   <= n_nxt;
      if (ld_fire) ld_sel <= !ld_sel;
    end
  end

endmodule

// File: rtl/dcfifo_rctl.sv
`timescale 1ns/1ps
// Read-domain control: read pointer, empty / almost-empty flags, output register.
module dcfifo_rctl
  import dcfifo_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 9
) (
  input  logic          rclk,
  input  logic          rst,
  input  logic          rd_en_a,
  input  logic          rd_en_b,
  input  logic [AW:0]   wgray_q,
  input  logic [AW:0]   wgray_pre,
  input  logic [DW-1:0] mem_q,
  input  logic [AW-1:0] ofs_n,
  output logic          rd_fire,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] rd_data,
  output logic          empty_n,
  output logic          aempty_n,
  output logic [AW:0]   rd_count
);

  localparam int PW = AW + 1;

  logic [PW-1:0] rbin, rbin_nxt, wbin_q, wbin_pre, lvl_nxt;
  ptr_t          t_wq, t_wp, t_rg;

  assign rd_fire = rd_en_a && rd_en_b && empty_n;

  always_comb begin
    t_wq     = from_gray(ptr_t'(wgray_q));
    t_wp     = from_gray(ptr_t'(wgray_pre));
    wbin_q   = t_wq[PW-1:0];
    wbin_pre = t_wp[PW-1:0];
    rbin_nxt = rbin + PW'(rd_fire);
    lvl_nxt  = wbin_pre - rbin_nxt;
    t_rg     = to_gray(ptr_t'(rbin_nxt));
    rd_count = wbin_q - rbin;
    raddr    = rbin[AW-1:0];
  end

  always_ff @(posedge rclk or posedge rst) begin
    if (rst) begin
      rbin     <= '0;
      rgray    <= '0;
      rd_data  <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
    end else begin
      rbin     <= rbin_nxt;
      rgray    <= t_rg[PW-1:0];
      if (rd_fire) rd_data <= mem_q;
      empty_n  <= (lvl_nxt != '0);
      aempty_n <= (lvl_nxt > {1'b0, ofs_n});
    end
  end

endmodule

// File: rtl/dcfifo_flags.sv
`timescale 1ns/1ps
module dcfifo_flags #(
  parameter int DEPTH       = 512,
  parameter int DW          = 9,
  parameter bit DUAL_WEN    = 1'b0,
  parameter int DEF_OFS     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_en2_ld,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en_a,
  input  logic          rd_en_b,
  output logic [DW-1:0] rd_data,
  output logic          wr_full_n,
  output logic          wr_afull_n,
  output logic          rd_empty_n,
  output logic          rd_aempty_n
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  // Named internal events, also observed by the bound checker.
  logic          wr_fire, rd_fire;
  logic [AW-1:0] waddr, raddr, ofs_m, ofs_n;
  logic [PW-1:0] wgray, rgray, wg_q, wg_pre, rg_q, rg_pre;
  logic [PW-1:0] wr_count, rd_count;
  logic [DW-1:0] mem_q;

  dcfifo_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk (wclk),
    .we   (wr_fire),
    .waddr(waddr),
    .wdata(wr_data),
    .raddr(raddr),
    .rdata(mem_q)
  );

  dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk  (rclk),
    .rst  (rst),
    .d    (wgray),
    .q_pre(wg_pre),
    .q    (wg_q)
  );

  dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk  (wclk),
    .rst  (rst),
    .d    (rgray),
    .q_pre(rg_pre),
    .q    (rg_q)
  );

  dcfifo_wctl #(
    .DEPTH(DEPTH), .AW(AW), .DW(DW), .DUAL_WEN(DUAL_WEN), .DEF_OFS(DEF_OFS)
  ) u_wctl (
    .wclk     (wclk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_en2_ld(wr_en2_ld),
    .wr_data  (wr_data),
    .rgray_q  (rg_q),
    .rgray_pre(rg_pre),
    .wr_fire  (wr_fire),
    .waddr    (waddr),
    .wgray    (wgray),
    .full_n   (wr_full_n),
    .afull_n  (wr_afull_n),
    .wr_count (wr_count),
    .ofs_m    (ofs_m),
    .ofs_n    (ofs_n)
  );

  dcfifo_rctl #(.AW(AW), .DW(DW)) u_rctl (
    .rclk     (rclk),
    .rst      (rst),
    .rd_en_a  (rd_en_a),
    .rd_en_b  (rd_en_b),
    .wgray_q  (wg_q),
    .wgray_pre(wg_pre),
    .mem_q    (mem_q),
    .ofs_n    (ofs_n),
    .rd_fire  (rd_fire),
    .raddr    (raddr),
    .rgray    (rgray),
    .rd_data  (rd_data),
    .empty_n  (rd_empty_n),
    .aempty_n (rd_aempty_n),
    .rd_count (rd_count)
  );

endmodule

// File: rtl/dcfifo_flags_chk.sv
`timescale 1ns/1ps
module dcfifo_flags_chk #(
  parameter int DEPTH = 512,
  parameter int AW    = 9,
  parameter int DW    = 9
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst,
  input logic          wr_full_n,
  input logic          wr_afull_n,
  input logic          rd_empty_n,
  input logic          rd_aempty_n,
  input logic [DW-1:0] rd_data,
  input logic [AW:0]   wr_count,
  input logic [AW:0]   rd_count,
  input logic [AW-1:0] ofs_m,
  input logic [AW:0]   wgray,
  input logic [AW:0]   rgray
);

  // R2: full flag low exactly at DEPTH unread words
  a_r2_full_matches_level: assert property (@(posedge wclk) disable iff (rst)
    wr_full_n == (int'(wr_count) != DEPTH));

  // R2: write-side level never exceeds capacity
  a_r2_no_overflow: assert property (@(posedge wclk) disable iff (rst)
    int'(wr_count) <= DEPTH);

  // R6: almost-full follows the threshold DEPTH - m
  a_r6_afull_threshold: assert property (@(posedge wclk) disable iff (rst)
    wr_afull_n == (int'(wr_count) < DEPTH - int'(ofs_m)));

  // R6: full implies almost-full
  a_r6_full_implies_afull: assert property (@(posedge wclk) disable iff (rst)
    !wr_full_n |-> !wr_afull_n);

  // R4: empty flag low exactly when nothing is unread
  a_r4_empty_matches_level: assert property (@(posedge rclk) disable iff (rst)
    rd_empty_n == (rd_count != '0));

  // R4: no read while empty, so the output register holds
  a_r4_hold_when_empty: assert property (@(posedge rclk) disable iff (rst)
    !rd_empty_n |=> $stable(rd_data));

  // R4: read-side level never exceeds capacity
  a_r4_no_underflow: assert property (@(posedge rclk) disable iff (rst)
    int'(rd_count) <= DEPTH);

  // R7: empty implies almost-empty
  a_r7_empty_implies_aempty: assert property (@(posedge rclk) disable iff (rst)
    !rd_empty_n |-> !rd_aempty_n);

  // R9: write Gray pointer moves by at most one bit per edge
  a_r9_wgray_one_bit: assert property (@(posedge wclk) disable iff (rst)
    $onehot0(wgray ^ $past(wgray)));

  // R9: read Gray pointer moves by at most one bit per edge
  a_r9_rgray_one_bit: assert property (@(posedge rclk) disable iff (rst)
    $onehot0(rgray ^ $past(rgray)));

endmodule

bind dcfifo_flags dcfifo_flags_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
  .wclk       (wclk),
  .rclk       (rclk),
  .rst        (rst),
  .wr_full_n  (wr_full_n),
  .wr_afull_n (wr_afull_n),
  .rd_empty_n (rd_empty_n),
  .rd_aempty_n(rd_aempty_n),
  .rd_data    (rd_data),
  .wr_count   (wr_count),
  .rd_count   (rd_count),
  .ofs_m      (ofs_m),
  .wgray      (wgray),
  .rgray      (rgray)
);

// File: tb/test_dcfifo_flags.sv
`timescale 1ns/1ps
module test_dcfifo_flags;

  localparam int DEPTH = 16;
  localparam int DW    = 9;

  logic wclk = 1'b0;
  logic rclk = 1'b0;
  logic rst  = 1'b1;

  // Programmable-flag instance
  logic          wr_en = 1'b0, wr_ld = 1'b0, ra = 1'b0, rb = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          full_n, afull_n, empty_n, aempty_n;

  // Two-write-enable instance
  logic          d_wen = 1'b0, d_en2 = 1'b0, d_ren = 1'b0;
  logic [DW-1:0] d_wdata = '0;
  logic [DW-1:0] d_rdata;
  logic          d_full_n, d_afull_n, d_empty_n, d_aempty_n;

  always #2 wclk = ~wclk;                       // 250 MHz
  initial begin #0.3; forever #3.5 rclk = ~rclk; end

  dcfifo_flags #(.DEPTH(DEPTH), .DW(DW), .DUAL_WEN(1'b0)) i_dcfifo_flags (
    .wclk(wclk), .rclk(rclk), .rst(rst),
    .wr_en(wr_en), .wr_en2_ld(wr_ld), .wr_data(wr_data),
    .rd_en_a(ra), .rd_en_b(rb), .rd_data(rd_data),
    .wr_full_n(full_n), .wr_afull_n(afull_n),
    .rd_empty_n(empty_n), .rd_aempty_n(aempty_n)
  );

  dcfifo_flags #(.DEPTH(DEPTH), .DW(DW), .DUAL_WEN(1'b1)) i_dcfifo_flags_dual (
    .wclk(wclk), .rclk(rclk), .rst(rst),
    .wr_en(d_wen), .wr_en2_ld(d_en2), .wr_data(d_wdata),
    .rd_en_a(d_ren), .rd_en_b(d_ren), .rd_data(d_rdata),
    .wr_full_n(d_full_n), .wr_afull_n(d_afull_n),
    .rd_empty_n(d_empty_n), .rd_aempty_n(d_aempty_n)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  task automatic cmp(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model: a queue of accepted words.
  logic [DW-1:0] mq[$];
  logic [DW-1:0] exp_w = '0;
  logic [DW-1:0] last_q = '0;
  bit            pend = 1'b0;

  // Inputs change 1 ns after a rising edge, so a falling edge shows the
  // values the next rising edge will act on.
  always @(negedge wclk) begin
    if (rst) mq.delete();
    else if (wr_en && !wr_ld && full_n) mq.push_back(wr_data);
  end

  always @(negedge rclk) begin
    if (rst) begin
      pend   = 1'b0;
      last_q = rd_data;
    end else begin
      if (pend) cmp("R1 read order", int'(rd_data), int'(exp_w));
      else      cmp("R4 output holds without read", int'(rd_data), int'(last_q));
      last_q = rd_data;
      pend   = ra && rb && empty_n;
      if (pend) begin
        if (mq.size() == 0) begin
          cmp("R4 read while model empty", 1, 0);
          pend = 1'b0;
        end else begin
          exp_w = mq.pop_front();
        end
      end
    end
  end

  task automatic wbeat(input bit ld, input logic [DW-1:0] d);
    @(posedge wclk); #1 wr_en = 1'b1; wr_ld = ld; wr_data = d;
    @(posedge wclk); #1 wr_en = 1'b0; wr_ld = 1'b0;
  endtask

  task automatic rbeat();
    @(posedge rclk); #1 ra = 1'b1; rb = 1'b1;
    @(posedge rclk); #1 ra = 1'b0; rb = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(posedge rclk);
    repeat (4) @(posedge wclk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge wclk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      report();
      $finish;
    end
  end

  initial begin
    logic [15:0] lw, lr;
    int cnt;

    // R8: reset state
    repeat (4) @(posedge wclk);
    @(negedge wclk);
    cmp("R8 rd_data after reset",     int'(rd_data), 0);
    cmp("R8 empty after reset",       int'(empty_n), 0);
    cmp("R8 almost-empty after reset", int'(aempty_n), 0);
    cmp("R8 full after reset",        int'(full_n), 1);
    cmp("R8 almost-full after reset", int'(afull_n), 1);
    @(posedge wclk); #1 rst = 1'b0;

    // R2 / R6: fill past capacity, default m = 7
    for (int k = 1; k <= 17; k++) begin
      wbeat(1'b0, DW'(k * 7 + 3));
      @(negedge wclk);
      cnt = (k > 16) ? 16 : k;
      cmp("R2 full flag while filling", int'(full_n), int'(cnt != 16));
      cmp("R6 almost-full while filling", int'(afull_n), int'(cnt < 9));
    end
    settle();
    @(negedge rclk);
    cmp("R4 not empty when full", int'(empty_n), 1);
    cmp("R7 not almost-empty when full", int'(aempty_n), 1);

    // R4 / R7 / R2 / R6: drain one word at a time
    for (int k = 15; k >= 0; k--) begin
      rbeat();
      @(negedge rclk);
      cmp("R4 empty flag while draining", int'(empty_n), int'(k != 0));
      cmp("R7 almost-empty while draining", int'(aempty_n), int'(k > 7));
      settle();
      @(negedge wclk);
      cmp("R2 full released", int'(full_n), 1);
      cmp("R6 almost-full release", int'(afull_n), int'(k < 9));
    end

    // R4: reads blocked while empty
    @(posedge rclk); #1 ra = 1'b1; rb = 1'b1;
    repeat (5) @(posedge rclk);
    #1 ra = 1'b0; rb = 1'b0;
    @(negedge rclk);
    cmp("R4 data held when empty", int'(rd_data), 16 * 7 + 3);
    cmp("R4 still empty", int'(empty_n), 0);

    // R10: first-word latency into an empty FIFO
    wbeat(1'b0, 9'h0AA);
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(posedge rclk);
      cnt++;
      @(negedge rclk);
      if (empty_n) break;
    end
    cmp("R10 empty rises on second read edge", cnt, 2);

    // R4: a single read enable does not read
    @(posedge rclk); #1 ra = 1'b1; rb = 1'b0;
    repeat (3) @(posedge rclk);
    #1 ra = 1'b0;
    @(negedge rclk);
    cmp("R4 one enable leaves word", int'(empty_n), 1);
    cmp("R4 one enable keeps data", int'(rd_data), 16 * 7 + 3);
    rbeat();
    @(negedge rclk);
    cmp("R1 word read after latency test", int'(rd_data), 'h0AA);

    // R5: load m = 3 then n = 12; nothing is written
    wbeat(1'b1, 9'd3);
    wbeat(1'b1, 9'd12);
    settle();
    @(negedge rclk);
    cmp("R5 load writes no word", int'(empty_n), 0);
    for (int k = 1; k <= 13; k++) begin
      wbeat(1'b0, DW'(200 + k));
      @(negedge wclk);
      cmp("R5 R6 loaded m threshold", int'(afull_n), int'(k < 13));
      if (k >= 12) begin
        settle();
        @(negedge rclk);
        cmp("R5 R7 loaded n threshold", int'(aempty_n), int'(k > 12));
      end
    end
    @(posedge rclk); #1 ra = 1'b1; rb = 1'b1;
    repeat (20) @(posedge rclk);
    #1 ra = 1'b0; rb = 1'b0;
    settle();
    @(negedge rclk);
    cmp("R1 drained after load test", int'(empty_n), 0);

    // R1 / R9: concurrent traffic with irregular enables
    lw = 16'hACE1;
    lr = 16'h1D2B;
    fork
      begin
        for (int i = 0; i < 250; i++) begin
          @(posedge wclk); #1
          lw = {lw[14:0], lw[15] ^ lw[13] ^ lw[12] ^ lw[10]};
          wr_en   = lw[0] | lw[3];
          wr_data = lw[8:0];
        end
        @(posedge wclk); #1 wr_en = 1'b0;
      end
      begin
        for (int i = 0; i < 150; i++) begin
          @(posedge rclk); #1
          lr = {lr[14:0], lr[15] ^ lr[13] ^ lr[12] ^ lr[10]};
          ra = lr[1] | lr[4];
          rb = lr[0] | lr[2];
        end
        @(posedge rclk); #1 ra = 1'b0; rb = 1'b0;
      end
    join
    @(posedge rclk); #1 ra = 1'b1; rb = 1'b1;
    repeat (40) @(posedge rclk);
    #1 ra = 1'b0; rb = 1'b0;
    settle();
    @(negedge rclk);
    cmp("R1 every accepted word delivered", mq.size(), 0);
    cmp("R1 empty after stream", int'(empty_n), 0);

    // R3: second write enable qualifies writes
    @(posedge wclk); #1 d_wen = 1'b1; d_en2 = 1'b0; d_wdata = 9'h155;
    @(posedge wclk); #1 d_wen = 1'b0;
    settle();
    @(negedge rclk);
    cmp("R3 second enable low blocks write", int'(d_empty_n), 0);
    @(posedge wclk); #1 d_wen = 1'b1; d_en2 = 1'b1; d_wdata = 9'h1A5;
    @(posedge wclk); #1 d_wen = 1'b0; d_en2 = 1'b0;
    settle();
    @(negedge rclk);
    cmp("R3 both enables write", int'(d_empty_n), 1);
    @(posedge rclk); #1 d_ren = 1'b1;
    @(posedge rclk); #1 d_ren = 1'b0;
    @(negedge rclk);
    cmp("R3 word read back", int'(d_rdata), 'h1A5);

    // R8: reset in mid-traffic restores flags, data and default offsets
    for (int k = 0; k < 3; k++) wbeat(1'b0, DW'(k + 40));
    settle();
    rbeat();
    @(posedge wclk); #1 rst = 1'b1;
    repeat (3) @(posedge wclk);
    @(negedge wclk);
    cmp("R8 rd_data cleared", int'(rd_data), 0);
    cmp("R8 empty restored", int'(empty_n), 0);
    cmp("R8 almost-empty restored", int'(aempty_n), 0);
    cmp("R8 full restored", int'(full_n), 1);
    cmp("R8 almost-full restored", int'(afull_n), 1);
    @(posedge wclk); #1 rst = 1'b0;
    for (int k = 1; k <= 9; k++) begin
      wbeat(1'b0, DW'(k));
      @(negedge wclk);
      cmp("R8 default m after reset", int'(afull_n), int'(k < 9));
    end
    settle();
    @(negedge rclk);
    cmp("R8 default n after reset", int'(aempty_n), 1);

    done = 1'b1;
    report();
    $finish;
  end

endmodule